// File: doc/BRIEF.md
# Paired Output Compare Channels

This block holds two output compare channels that share one up/down timer counter. Each channel compares the counter with its own active compare value and drives a registered reference level. The channel's 4-bit mode decides how the reference moves: it can change on a match, be forced to a fixed level, generate edge- or center-aligned PWM, or act as a retriggerable one-pulse generator. The counter, its direction, the update-event pulse, the trigger pulse and the external clear input all come from outside the block.

The pair also drives a combined reference. Its behaviour is selected by the first channel's mode. In the combined modes it is the OR or the AND of the two channel references. In the asymmetric modes it follows the first channel while the counter counts up and the second channel while it counts down. In every other mode it simply repeats the first channel's reference.

Each channel's compare value can be written directly to the active register. It can instead go into a shadow register that is copied to the active register on an update event, so a new duty cycle takes effect only at a period boundary.

Top module: `oc_pair`

## Requirements
- R1: While `rst` is high at a clock edge, `ref_a`, `ref_b` and `ref_comb` are low after that edge, whatever the other inputs are. All internal compare and sequencing state is cleared at the same time.
- R2: Configuration word layout:
  - bits 6:4 hold the low three mode bits and bit 16 holds the mode's extension bit, so the mode code is {bit16, bits 6:4};
  - bit 2 is fast enable, bit 3 is preload enable and bit 7 is clear enable.
  A match means `cnt` equals the active compare value. On a match, code 1 drives the reference high, code 2 drives it low and code 3 inverts it. Without a match, these codes hold the reference.
- R3: Code 4 makes the reference low and code 5 makes it high, on the clock edge after the code is applied.
- R4: Code 0 and the reserved codes 10 and 11 hold the reference at its previous level, even when the counter matches.
- R5: Code 6 (PWM 1) gives a high reference when `cnt` < compare while counting up (`cnt_down`=0), and when `cnt` <= compare while counting down. Code 7 gives the inverse of code 6.
- R6: With preload enable at 0, a write (`cmp_wr` bit 0 for the first channel, bit 1 for the second) reaches the active compare value on the next edge. With preload enable at 1, the write lands in a shadow register and becomes active only on the edge where `upd_evt` is high.
- R7: With clear enable at 1, a high `ext_clr` drives the reference low. The reference stays low until an update event has passed. With clear enable at 0, `ext_clr` has no effect.
- R8: Code 8 (one-pulse 1) while counting up:
  - the reference is high until it trips;
  - a `trig` pulse arms the channel, and the next compare match trips it, which drives the reference low;
  - a match with no arming does nothing;
  - `upd_evt` clears both the armed and the tripped state.
  While counting down, the reference is low. Code 9 gives the inverse levels.
- R9: In codes 8 and 9 with fast enable at 1, the trigger trips the channel directly, so the reference changes on the edge that samples `trig`.
- R10: With the first channel in code 12, `ref_comb` is the OR of both references. In code 13 it is the AND of both references. Each channel produces PWM 1 in code 12 and PWM 2 in code 13. In codes below 12, `ref_comb` equals `ref_a`.
- R11: In codes 14 and 15, `ref_comb` equals `ref_a` while counting up and `ref_b` while counting down. Each channel produces PWM 1 in code 14 and PWM 2 in code 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Counter direction, 1 = counting down |
| upd_evt | input | 1 | Update-event pulse |
| trig | input | 1 | Trigger pulse for one-pulse modes |
| ext_clr | input | 1 | External clear request |
| cfg_a | input | 17 | First channel configuration word |
| cfg_b | input | 17 | Second channel configuration word |
| cmp_wr | input | 2 | Compare write strobes, bit 0 first channel, bit 1 second |
| cmp_wdata | input | CNT_W | Compare write data |
| ref_a | output | 1 | First channel reference |
| ref_b | output | 1 | Second channel reference |
| ref_comb | output | 1 | Combined reference of the pair |

## Verification
The hardest state to reach is a one-pulse channel that is armed but not yet tripped. The reference looks the same before and after the trigger, and only a later match can show that the trigger was captured. The bench first clears the sequencer with an update pulse. It then checks that an unarmed match leaves the reference high, pulses the trigger away from the compare value, and then steps the counter onto the compare value to see the trip. A similar hidden state arises when the clear is held low after `ext_clr` has already dropped. The bench exposes it by using force-high mode, so that only the latched clear can keep the reference low until the update pulse.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int CFG_W    = 17;
  localparam int FAST_BIT = 2;
  localparam int PRE_BIT  = 3;
  localparam int MODE_LSB = 4;
  localparam int CLR_BIT  = 7;
  localparam int EXT_BIT  = 16;

  typedef enum logic [3:0] {
    MD_FROZEN = 4'd0,
    MD_SET    = 4'd1,
    MD_CLR    = 4'd2,
    MD_TOG    = 4'd3,
    MD_LOW    = 4'd4,
    MD_HIGH   = 4'd5,
    MD_PWM1   = 4'd6,
    MD_PWM2   = 4'd7,
    MD_OPM1   = 4'd8,
    MD_OPM2   = 4'd9,
    MD_RSV10  = 4'd10,
    MD_RSV11  = 4'd11,
    MD_CPWM1  = 4'd12,
    MD_CPWM2  = 4'd13,
    MD_APWM1  = 4'd14,
    MD_APWM2  = 4'd15
  } oc_mode_e;

  typedef struct packed {
    oc_mode_e mode;
    logic     fast;
    logic     preload;
    logic     clr_en;
  } oc_cfg_t;
endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preload,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             upd,
  output logic [CNT_W-1:0] active
);
  logic [CNT_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active   <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (!preload) begin
        if (wr) active <= wdata;
      end else if (upd) begin
        active <= wr ? wdata : shadow_q;
      end
    end
  end

  // R6
  preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (preload && !upd) |=> $stable(active));

  // R6
  direct_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!preload && wr) |=> (active == $past(wdata)));
endmodule

// File: rtl/oc_chan_ref.sv
module oc_chan_ref
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  oc_cfg_t          cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cmp,
  input  logic             upd,
  input  logic             trig,
  input  logic             ext_clr,
  output logic             ref_nxt,
  output logic             ref_q
);
  logic match, pwm1, clr_hold_q, clr_force;
  logic armed_q, tripped_q, armed_n, tripped_n;

  assign match = (cnt == cmp);
  assign pwm1  = cnt_down ? !(cnt > cmp) : (cnt < cmp);

  // clear request latched until the next update event
  always_ff @(posedge clk) begin
    if (rst)                           clr_hold_q <= 1'b0;
    else if (cfg.clr_en && ext_clr)    clr_hold_q <= 1'b1;
    else if (upd)                      clr_hold_q <= 1'b0;
  end
  assign clr_force = cfg.clr_en && (ext_clr || clr_hold_q);

  // one-pulse sequencer: trigger arms, match (or fast trigger) trips
  always_comb begin
    if (upd) begin
      armed_n   = 1'b0;
      tripped_n = 1'b0;
    end else begin
      armed_n   = (armed_q && !match) || (trig && !cfg.fast);
      tripped_n = tripped_q || (trig && cfg.fast) || (armed_q && match);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      tripped_q <= 1'b0;
    end else begin
      armed_q   <= armed_n;
      tripped_q <= tripped_n;
    end
  end

  always_comb begin
    ref_nxt = ref_q;
    case (cfg.mode)
      MD_SET:  if (match) ref_nxt = 1'b1;
      MD_CLR:  if (match) ref_nxt = 1'b0;
      MD_TOG:  if (match) ref_nxt = !ref_q;
      MD_LOW:  ref_nxt = 1'b0;
      MD_HIGH: ref_nxt = 1'b1;
      MD_PWM1, MD_CPWM1, MD_APWM1: ref_nxt = pwm1;
      MD_PWM2, MD_CPWM2, MD_APWM2: ref_nxt = !pwm1;
      MD_OPM1: ref_nxt = !cnt_down && !tripped_n;
      MD_OPM2: ref_nxt = cnt_down || tripped_n;
      default: ref_nxt = ref_q;
    endcase
    if (clr_force) ref_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_nxt;
  end

  // R3
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MD_LOW) |=> !ref_q);

  // R3
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MD_HIGH && !clr_force) |=> ref_q);

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg.mode == MD_FROZEN || cfg.mode == MD_RSV10 || cfg.mode == MD_RSV11)
      && !clr_force) |=> $stable(ref_q));

  // R7
  ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.clr_en && ext_clr) |=> !ref_q);

  // R8
  opm_down_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MD_OPM1 && cnt_down) |=> !ref_q);

  // R9
  fast_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MD_OPM1 && cfg.fast && trig && !upd && !cnt_down) |=> !ref_q);
endmodule

// File: rtl/oc_combine.sv
module oc_combine
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  oc_mode_e mode_a,
  input  logic     cnt_down,
  input  logic     a_nxt,
  input  logic     b_nxt,
  input  logic     a_q,
  input  logic     b_q,
  output logic     comb_q
);
  logic comb_nxt;

  always_comb begin
    case (mode_a)
      MD_CPWM1:           comb_nxt = a_nxt | b_nxt;
      MD_CPWM2:           comb_nxt = a_nxt & b_nxt;
      MD_APWM1, MD_APWM2: comb_nxt = cnt_down ? b_nxt : a_nxt;
      default:            comb_nxt = a_nxt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) comb_q <= 1'b0;
    else     comb_q <= comb_nxt;
  end

  // R10
  comb_or_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_a == MD_CPWM1) |=> (comb_q == (a_q | b_q)));

  // R10
  comb_and_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_a == MD_CPWM2) |=> (comb_q == (a_q & b_q)));

  // R11
  asym_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_a == MD_APWM1 || mode_a == MD_APWM2) && cnt_down) |=> (comb_q == b_q));
endmodule

// File: rtl/oc_pair.sv
module oc_pair
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             trig,
  input  logic             ext_clr,
  input  logic [CFG_W-1:0] cfg_a,
  input  logic [CFG_W-1:0] cfg_b,
  input  logic [1:0]       cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             ref_a,
  output logic             ref_b,
  output logic             ref_comb
);
  localparam int NCH = 2;

  logic [CFG_W-1:0] cfg_w   [NCH];
  oc_cfg_t          cfg_d   [NCH];
  logic [CNT_W-1:0] act_cmp [NCH];
  logic             r_nxt   [NCH];
  logic             r_q     [NCH];
  logic             unused_cfg_bits;

  assign cfg_w[0] = cfg_a;
  assign cfg_w[1] = cfg_b;
  assign unused_cfg_bits = ^{cfg_a[1:0], cfg_a[15:8], cfg_b[1:0], cfg_b[15:8]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg_d[i].mode    = oc_mode_e'({cfg_w[i][EXT_BIT], cfg_w[i][MODE_LSB+2:MODE_LSB]});
    assign cfg_d[i].fast    = cfg_w[i][FAST_BIT];
    assign cfg_d[i].preload = cfg_w[i][PRE_BIT];
    assign cfg_d[i].clr_en  = cfg_w[i][CLR_BIT];

    oc_cmp_store #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .preload (cfg_d[i].preload),
      .wr      (cmp_wr[i]),
      .wdata   (cmp_wdata),
      .upd     (upd_evt),
      .active  (act_cmp[i])
    );

    oc_chan_ref #(.CNT_W(CNT_W)) u_ref (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg_d[i]),
      .cnt      (cnt),
      .cnt_down (cnt_down),
      .cmp      (act_cmp[i]),
      .upd      (upd_evt),
      .trig     (trig),
      .ext_clr  (ext_clr),
      .ref_nxt  (r_nxt[i]),
      .ref_q    (r_q[i])
    );
  end

  oc_combine u_comb (
    .clk      (clk),
    .rst      (rst),
    .mode_a   (cfg_d[0].mode),
    .cnt_down (cnt_down),
    .a_nxt    (r_nxt[0]),
    .b_nxt    (r_nxt[1]),
    .a_q      (r_q[0]),
    .b_q      (r_q[1]),
    .comb_q   (ref_comb)
  );

  assign ref_a = r_q[0];
  assign ref_b = r_q[1];

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!ref_a && !ref_b && !ref_comb));
endmodule

// File: tb/oc_pair_tb.sv
module oc_pair_tb;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] cnt;
  logic             cnt_down, upd_evt, trig, ext_clr;
  logic [16:0]      cfg_a, cfg_b;
  logic [1:0]       cmp_wr;
  logic [CNT_W-1:0] cmp_wdata;
  logic             ref_a, ref_b, ref_comb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  oc_pair #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_down(cnt_down), .upd_evt(upd_evt),
    .trig(trig), .ext_clr(ext_clr), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ref_a(ref_a), .ref_b(ref_b), .ref_comb(ref_comb)
  );

  // mode code {ext, m2:m0}; fast bit 2, preload bit 3, mode 6:4, clear-en 7, ext 16
  function automatic logic [16:0] mk(input int code, input bit fast = 0,
                                     input bit pre = 0, input bit clr = 0);
    logic [16:0] w = '0;
    w[6:4] = code[2:0];
    w[16]  = code[3];
    w[2]   = fast;
    w[3]   = pre;
    w[7]   = clr;
    return w;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_cmp(input logic [1:0] sel, input int val);
    cmp_wr = sel; cmp_wdata = CNT_W'(val);
    tick();
    cmp_wr = 2'b00;
  endtask

  task automatic pulse_upd();
    upd_evt = 1'b1; tick(); upd_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; cfg_a = mk(5); tick(); tick();
    chk("R1", "ref_a in reset", ref_a, 1'b0);
    chk("R1", "ref_comb in reset", ref_comb, 1'b0);
    cfg_a = mk(0); tick();
    rst = 1'b0; tick();
    chk("R1", "ref_a after reset", ref_a, 1'b0);
    chk("R1", "ref_b after reset", ref_b, 1'b0);
  endtask

  task automatic t_force();
    cfg_a = mk(5); tick(); chk("R3", "force high", ref_a, 1'b1);
    cfg_a = mk(4); tick(); chk("R3", "force low", ref_a, 1'b0);
  endtask

  task automatic t_match();
    cfg_a = mk(0); write_cmp(2'b01, 10);
    cfg_a = mk(1); cnt = 5;  tick(); chk("R2", "set no match", ref_a, 1'b0);
    cnt = 10;                tick(); chk("R2", "set on match", ref_a, 1'b1);
    cfg_a = mk(2);           tick(); chk("R2", "clear on match", ref_a, 1'b0);
    cfg_a = mk(3);           tick(); chk("R2", "toggle 1", ref_a, 1'b1);
                             tick(); chk("R2", "toggle 2", ref_a, 1'b0);
                             tick(); chk("R2", "toggle 3", ref_a, 1'b1);
    cnt = 11;                tick(); chk("R2", "toggle no match", ref_a, 1'b1);
  endtask

  task automatic t_hold();
    cnt = 10;
    cfg_a = mk(0);  tick(); chk("R4", "frozen hold high", ref_a, 1'b1);
    cfg_a = mk(10); tick(); chk("R4", "reserved 10 hold", ref_a, 1'b1);
    cfg_a = mk(4);  tick();
    cfg_a = mk(11); tick(); chk("R4", "reserved 11 hold low", ref_a, 1'b0);
  endtask

  task automatic t_pwm();
    cfg_a = mk(6); cnt_down = 0;
    cnt = 9;  tick(); chk("R5", "pwm1 up below", ref_a, 1'b1);
    cnt = 10; tick(); chk("R5", "pwm1 up equal", ref_a, 1'b0);
    cnt_down = 1;
    cnt = 11; tick(); chk("R5", "pwm1 down above", ref_a, 1'b0);
    cnt = 10; tick(); chk("R5", "pwm1 down equal", ref_a, 1'b1);
    cfg_a = mk(7);
              tick(); chk("R5", "pwm2 down equal", ref_a, 1'b0);
    cnt_down = 0; cnt = 9;
              tick(); chk("R5", "pwm2 up below", ref_a, 1'b0);
    cnt = 12; tick(); chk("R5", "pwm2 up above", ref_a, 1'b1);
  endtask

  task automatic t_preload();
    cfg_a = mk(6, 0, 1); cnt_down = 0; cnt = 15;
    tick(); chk("R6", "preload old compare", ref_a, 1'b0);
    write_cmp(2'b01, 20);
    chk("R6", "shadow write not active", ref_a, 1'b0);
    tick(); chk("R6", "still old compare", ref_a, 1'b0);
    pulse_upd();
    tick(); chk("R6", "new compare after update", ref_a, 1'b1);
    cfg_a = mk(6);
    write_cmp(2'b01, 12);
    tick(); chk("R6", "direct write", ref_a, 1'b0);
  endtask

  task automatic t_clear();
    cfg_a = mk(5, 0, 0, 1);
    tick(); chk("R7", "high before clear", ref_a, 1'b1);
    ext_clr = 1; tick(); ext_clr = 0;
    chk("R7", "cleared", ref_a, 1'b0);
    tick(); chk("R7", "clear held", ref_a, 1'b0);
    pulse_upd();
    chk("R7", "clear held at update", ref_a, 1'b0);
    tick(); chk("R7", "released after update", ref_a, 1'b1);
    cfg_a = mk(5); ext_clr = 1; tick(); ext_clr = 0;
    chk("R7", "clear ignored when disabled", ref_a, 1'b1);
    tick();
  endtask

  task automatic t_opm();
    cfg_a = mk(0); write_cmp(2'b01, 30);
    cfg_a = mk(8); cnt_down = 0; cnt = 0;
    pulse_upd(); chk("R8", "opm1 idle high", ref_a, 1'b1);
    cnt = 30; tick(); chk("R8", "unarmed match ignored", ref_a, 1'b1);
    cnt = 5; trig = 1; tick(); trig = 0;
    chk("R8", "armed, no trip yet", ref_a, 1'b1);
    cnt = 30; tick(); chk("R8", "trip on match", ref_a, 1'b0);
    cnt = 31; tick(); chk("R8", "stays tripped", ref_a, 1'b0);
    pulse_upd(); chk("R8", "update rearms", ref_a, 1'b1);
    cnt_down = 1; tick(); chk("R8", "down inactive", ref_a, 1'b0);
    cnt_down = 0;
    cfg_a = mk(9); cnt = 0;
    pulse_upd(); chk("R8", "opm2 idle low", ref_a, 1'b0);
    cnt = 5; trig = 1; tick(); trig = 0;
    chk("R8", "opm2 armed", ref_a, 1'b0);
    cnt = 30; tick(); chk("R8", "opm2 trip", ref_a, 1'b1);
  endtask

  task automatic t_fast();
    cfg_a = mk(8, 1); cnt_down = 0; cnt = 0;
    pulse_upd(); chk("R9", "fast opm1 idle", ref_a, 1'b1);
    cnt = 5; trig = 1; tick(); trig = 0;
    chk("R9", "fast trip on trigger", ref_a, 1'b0);
    pulse_upd(); chk("R9", "fast rearm", ref_a, 1'b1);
    cfg_a = mk(9, 1);
    pulse_upd(); chk("R9", "fast opm2 idle", ref_a, 1'b0);
    trig = 1; tick(); trig = 0;
    chk("R9", "fast opm2 trip", ref_a, 1'b1);
  endtask

  task automatic t_comb();
    cfg_a = mk(0); cfg_b = mk(0);
    write_cmp(2'b01, 10);
    write_cmp(2'b10, 20);
    cfg_a = mk(12); cfg_b = mk(12); cnt_down = 0;
    cnt = 5;  tick(); chk("R10", "or both high", ref_comb, 1'b1);
    chk("R10", "ref_b pwm1", ref_b, 1'b1);
    cnt = 15; tick(); chk("R10", "or one high", ref_comb, 1'b1);
    chk("R10", "ref_a low", ref_a, 1'b0);
    cnt = 25; tick(); chk("R10", "or none high", ref_comb, 1'b0);
    cfg_a = mk(13); cfg_b = mk(13);
    cnt = 15; tick(); chk("R10", "and one high", ref_comb, 1'b0);
    cnt = 25; tick(); chk("R10", "and both high", ref_comb, 1'b1);
    cfg_a = mk(5); cfg_b = mk(4);
    tick(); chk("R10", "plain mode follows a", ref_comb, 1'b1);
  endtask

  task automatic t_asym();
    cfg_a = mk(14); cfg_b = mk(14); cnt = 15;
    cnt_down = 0; tick(); chk("R11", "asym1 up picks a", ref_comb, 1'b0);
    cnt_down = 1; tick(); chk("R11", "asym1 down picks b", ref_comb, 1'b1);
    cfg_a = mk(15); cfg_b = mk(15);
    tick(); chk("R11", "asym2 down picks b", ref_comb, 1'b0);
    cnt_down = 0; tick(); chk("R11", "asym2 up picks a", ref_comb, 1'b1);
  endtask

  initial begin
    rst = 1; cnt = '0; cnt_down = 0; upd_evt = 0; trig = 0; ext_clr = 0;
    cfg_a = '0; cfg_b = '0; cmp_wr = '0; cmp_wdata = '0;
    t_reset();
    t_force();
    t_match();
    t_hold();
    t_pwm();
    t_preload();
    t_clear();
    t_opm();
    t_fast();
    t_comb();
    t_asym();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule